// File: doc/BRIEF.md
# Configurable NaN Classifier and Quieter

This unit inspects one IEEE binary floating-point word and tells the surrounding datapath whether the word is a NaN and, if so, whether that NaN is quiet or signaling. It also delivers two words the datapath usually needs next to the classification: the operand after quieting, and the default NaN pattern for the active polarity. The unit is purely combinational, holds no state and raises no exception flags. The caller decides what to do with a signaling result.

A format parameter selects the split between exponent and fraction: 5/10 (half), 8/7 (bfloat16), 8/23 (single, the default) or 11/52 (double). Two run-time inputs shape the classification. One inverts the meaning of the top fraction bit, so that a set bit marks a signaling NaN. The other switches off signaling detection, so that every NaN reports as quiet. The sign of the default NaN is a parameter and defaults to 0.

Top module: `nan_quieter`

## Requirements
- R1: `is_nan_o` is 1 exactly when the exponent field is all ones and the fraction field is nonzero, in every mode.
- R2: An infinity (all-ones exponent, zero fraction, either sign) gives 0 on `is_nan_o`, `is_qnan_o` and `is_snan_o` in every mode.
- R3: With `sig_inv_i`=0 and `nosig_i`=0, a NaN whose top fraction bit is 1 is quiet, and a NaN whose top fraction bit is 0 (with a nonzero rest of the fraction) is signaling.
- R4: With `sig_inv_i`=1 and `nosig_i`=0, a NaN whose top fraction bit is 1 is signaling, and a NaN whose top fraction bit is 0 (with a nonzero rest of the fraction) is quiet.
- R5: With `nosig_i`=1, every NaN reports as quiet and `is_snan_o` stays 0, whatever the value of `sig_inv_i`.
- R6: `is_qnan_o` and `is_snan_o` are never both 1, and their OR equals `is_nan_o`.
- R7: With `sig_inv_i`=0, `dflt_nan_o` is the configured sign, an all-ones exponent and a fraction with only its top bit set (0x7FC00000 for single with sign 0).
- R8: With `sig_inv_i`=1, `dflt_nan_o` is the configured sign, an all-ones exponent and a fraction with every bit set except the top one (0x7FBFFFFF for single with sign 0).
- R9: With `sig_inv_i`=0, a signaling NaN is quieted by setting the top fraction bit. The sign, the exponent and all other fraction bits are kept.
- R10: With `sig_inv_i`=1, a signaling NaN is quieted by replacing it with `dflt_nan_o`. The operand payload has no effect on the result.
- R11: An operand that is not reported as signaling appears unchanged on `quieted_o`.
- R12: For the default single format, the sign is bit 31, the exponent is bits 30:23 and the fraction is bits 22:0, with bit 22 as the top fraction bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | WORD_W (32) | Floating-point word to classify |
| sig_inv_i | input | 1 | 1: a set top fraction bit marks a signaling NaN |
| nosig_i | input | 1 | 1: signaling detection disabled, all NaNs are quiet |
| is_nan_o | output | 1 | Operand is a NaN of either kind |
| is_qnan_o | output | 1 | Operand is a quiet NaN |
| is_snan_o | output | 1 | Operand is a signaling NaN |
| quieted_o | output | WORD_W (32) | Operand after quieting |
| dflt_nan_o | output | WORD_W (32) | Default NaN for the active polarity |

## Verification
The bound checker tests several properties on every evaluation. The two class outputs must be exclusive and together must cover `is_nan_o`. An infinity must never be classed as a NaN, and no-signaling mode must never report a signaling NaN. The checker also compares the quieted word with the operand in the three cases: pass-through, setting the top fraction bit, and substitution of the default NaN. Some behaviour depends on exact bit patterns and only the bench scenarios can show it. This covers the default NaN encodings for each polarity, the payload boundary where only the lowest fraction bit is set, and the all-ones fraction under inverted polarity. The bench also shows that `is_nan_o` stays independent of the mode inputs.

// File: rtl/nanq_pkg.sv
package nanq_pkg;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_BF16   = 2'd1,
        FMT_SINGLE = 2'd2,
        FMT_DOUBLE = 2'd3
    } fmt_e;

    typedef struct packed {
        logic sig_inv;
        logic nosig;
    } nan_mode_t;

    typedef struct packed {
        logic any;
        logic quiet;
        logic signaling;
    } nan_class_t;

    function automatic int exp_bits(fmt_e f);
        case (f)
            FMT_HALF:   return 5;
            FMT_BF16:   return 8;
            FMT_SINGLE: return 8;
            default:    return 11;
        endcase
    endfunction

    function automatic int frac_bits(fmt_e f);
        case (f)
            FMT_HALF:   return 10;
            FMT_BF16:   return 7;
            FMT_SINGLE: return 23;
            default:    return 52;
        endcase
    endfunction

endpackage

// File: rtl/nanq_fields.sv
module nanq_fields #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              exp_ones_o,
    output logic              frac_top_o,
    output logic              frac_rest_nz_o
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f          = word_i[WORD_W-2 -: EXP_W];
        frac_f         = word_i[FRAC_W-1:0];
        exp_ones_o     = &exp_f;
        frac_top_o     = frac_f[FRAC_W-1];
        frac_rest_nz_o = |frac_f[FRAC_W-2:0];
    end
endmodule

// File: rtl/nanq_classify.sv
module nanq_classify
    import nanq_pkg::*;
(
    input  logic       exp_ones_i,
    input  logic       frac_top_i,
    input  logic       frac_rest_nz_i,
    input  nan_mode_t  mode_i,
    output nan_class_t cls_o
);
    logic top_marks_quiet;

    always_comb begin
        top_marks_quiet = ~mode_i.sig_inv;
        cls_o.any       = exp_ones_i & (frac_top_i | frac_rest_nz_i);
        if (mode_i.nosig) begin
            cls_o.quiet     = cls_o.any;
            cls_o.signaling = 1'b0;
        end else if (top_marks_quiet) begin
            cls_o.quiet     = exp_ones_i & frac_top_i;
            cls_o.signaling = exp_ones_i & ~frac_top_i & frac_rest_nz_i;
        end else begin
            cls_o.signaling = exp_ones_i & frac_top_i;
            cls_o.quiet     = exp_ones_i & ~frac_top_i & frac_rest_nz_i;
        end
    end
endmodule

// File: rtl/nanq_quiet.sv
module nanq_quiet
    import nanq_pkg::*;
#(
    parameter int   EXP_W     = 8,
    parameter int   FRAC_W    = 23,
    parameter logic DNAN_SIGN = 1'b0,
    localparam int  WORD_W    = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] operand_i,
    input  nan_mode_t         mode_i,
    input  logic              is_snan_i,
    output logic [WORD_W-1:0] quieted_o,
    output logic [WORD_W-1:0] dflt_o
);
    localparam logic [FRAC_W-1:0] TOP_ONLY  = {1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [FRAC_W-1:0] BELOW_TOP = {1'b0, {(FRAC_W-1){1'b1}}};
    localparam logic [EXP_W-1:0]  EXP_MAX   = {EXP_W{1'b1}};

    always_comb begin
        dflt_o = {DNAN_SIGN, EXP_MAX, (mode_i.sig_inv ? BELOW_TOP : TOP_ONLY)};
        if (!is_snan_i) begin
            quieted_o = operand_i;
        end else if (mode_i.sig_inv) begin
            quieted_o = dflt_o;
        end else begin
            quieted_o = operand_i | {{(1 + EXP_W){1'b0}}, TOP_ONLY};
        end
    end
endmodule

// File: rtl/nan_quieter.sv
module nan_quieter
    import nanq_pkg::*;
#(
    parameter fmt_e FMT       = FMT_SINGLE,
    parameter logic DNAN_SIGN = 1'b0,
    localparam int  EXP_W     = exp_bits(FMT),
    localparam int  FRAC_W    = frac_bits(FMT),
    localparam int  WORD_W    = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] operand_i,
    input  logic              sig_inv_i,
    input  logic              nosig_i,
    output logic              is_nan_o,
    output logic              is_qnan_o,
    output logic              is_snan_o,
    output logic [WORD_W-1:0] quieted_o,
    output logic [WORD_W-1:0] dflt_nan_o
);
    nan_mode_t  mode;
    nan_class_t cls;
    logic       exp_ones, frac_top, frac_rest_nz;

    assign mode = '{sig_inv: sig_inv_i, nosig: nosig_i};

    nanq_fields #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fields (
        .word_i         (operand_i),
        .exp_ones_o     (exp_ones),
        .frac_top_o     (frac_top),
        .frac_rest_nz_o (frac_rest_nz)
    );

    nanq_classify u_classify (
        .exp_ones_i     (exp_ones),
        .frac_top_i     (frac_top),
        .frac_rest_nz_i (frac_rest_nz),
        .mode_i         (mode),
        .cls_o          (cls)
    );

    nanq_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .DNAN_SIGN(DNAN_SIGN)) u_quiet (
        .operand_i (operand_i),
        .mode_i    (mode),
        .is_snan_i (cls.signaling),
        .quieted_o (quieted_o),
        .dflt_o    (dflt_nan_o)
    );

    assign is_nan_o  = cls.any;
    assign is_qnan_o = cls.quiet;
    assign is_snan_o = cls.signaling;
endmodule

// File: rtl/nanq_checker.sv
module nanq_checker #(
    parameter int  EXP_W  = 8,
    parameter int  FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic [WORD_W-1:0] operand_i,
    input logic              sig_inv_i,
    input logic              nosig_i,
    input logic              is_nan_o,
    input logic              is_qnan_o,
    input logic              is_snan_o,
    input logic [WORD_W-1:0] quieted_o,
    input logic [WORD_W-1:0] dflt_nan_o
);
    logic [WORD_W-1:0] top_bit;
    logic              is_inf;

    always_comb begin
        top_bit = '0;
        top_bit[FRAC_W-1] = 1'b1;
        is_inf  = (&operand_i[WORD_W-2 -: EXP_W]) && (operand_i[FRAC_W-1:0] == '0);

        assert_class_exclusive_R6: assert (!(is_qnan_o && is_snan_o) && (is_nan_o == (is_qnan_o || is_snan_o)))
            else $error("class outputs inconsistent");
        assert_inf_not_nan_R2: assert (!(is_inf && is_nan_o))
            else $error("infinity classed as NaN");
        assert_nosig_quiet_R5: assert (!(nosig_i && is_snan_o))
            else $error("signaling reported in no-signaling mode");
        assert_passthrough_R11: assert (is_snan_o || quieted_o == operand_i)
            else $error("non-signaling operand altered");
        assert_set_top_R9: assert (!(is_snan_o && !sig_inv_i) || quieted_o == (operand_i | top_bit))
            else $error("normal-polarity quieting wrong");
        assert_use_default_R10: assert (!(is_snan_o && sig_inv_i) || quieted_o == dflt_nan_o)
            else $error("inverted-polarity quieting wrong");
    end
endmodule

bind nan_quieter nanq_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nanq_chk (
    .operand_i  (operand_i),
    .sig_inv_i  (sig_inv_i),
    .nosig_i    (nosig_i),
    .is_nan_o   (is_nan_o),
    .is_qnan_o  (is_qnan_o),
    .is_snan_o  (is_snan_o),
    .quieted_o  (quieted_o),
    .dflt_nan_o (dflt_nan_o)
);

// File: tb/tb_nan_quieter.sv
module tb_nan_quieter;
    localparam int EW = 8;
    localparam int FW = 23;
    localparam int W  = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] operand;
    logic         sig_inv, nosig;
    logic         is_nan, is_qnan, is_snan;
    logic [W-1:0] quieted, dflt;
    int           n_tests = 0;
    int           n_fail  = 0;
    int           cycles  = 0;

    always #4 clk = ~clk;

    nan_quieter dut (
        .operand_i  (operand),
        .sig_inv_i  (sig_inv),
        .nosig_i    (nosig),
        .is_nan_o   (is_nan),
        .is_qnan_o  (is_qnan),
        .is_snan_o  (is_snan),
        .quieted_o  (quieted),
        .dflt_nan_o (dflt)
    );

    function automatic logic [2:0] ref_class(logic [W-1:0] w, logic inv, logic ns);
        logic e1, top, rest, nan;
        e1   = (w[30:23] == 8'hFF);
        top  = w[22];
        rest = (w[21:0] != 22'd0);
        nan  = e1 && (top || rest);
        if (!nan)      return 3'b000;
        if (ns)        return 3'b110;
        if (top ^ inv) return 3'b110;
        return 3'b101;
    endfunction

    function automatic logic [W-1:0] ref_dflt(logic inv);
        return inv ? 32'h7FBF_FFFF : 32'h7FC0_0000;
    endfunction

    function automatic logic [W-1:0] ref_quiet(logic [W-1:0] w, logic inv, logic ns);
        logic [2:0] c;
        c = ref_class(w, inv, ns);
        if (!c[0]) return w;
        if (inv)   return ref_dflt(1'b1);
        return w | 32'h0040_0000;
    endfunction

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (op=%h inv=%0b nosig=%0b)",
                     req, what, act, exp, operand, sig_inv, nosig);
        end
    endtask

    task automatic apply(logic [W-1:0] w, logic inv, logic ns);
        logic [2:0] c;
        string      creq;
        @(negedge clk);
        operand = w; sig_inv = inv; nosig = ns;
        #1;
        c    = ref_class(w, inv, ns);
        creq = ns ? "R5" : (inv ? "R4" : "R3");
        check("R1", "is_nan", {31'd0, is_nan}, {31'd0, c[2]});
        check(creq, "is_qnan", {31'd0, is_qnan}, {31'd0, c[1]});
        check(creq, "is_snan", {31'd0, is_snan}, {31'd0, c[0]});
        check("R6", "class cover", {31'd0, is_qnan | is_snan}, {31'd0, is_nan});
        check(inv ? "R8" : "R7", "dflt", dflt, ref_dflt(inv));
        check(c[0] ? (inv ? "R10" : "R9") : "R11", "quieted", quieted, ref_quiet(w, inv, ns));
    endtask

    task automatic all_modes(logic [W-1:0] w);
        for (int m = 0; m < 4; m++) apply(w, m[0], m[1]);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [W-1:0] w;
        operand = '0; sig_inv = 1'b0; nosig = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-state / zero operand: no NaN, passthrough of zero
        @(negedge clk); #1;
        check("R1", "zero is_nan", {31'd0, is_nan}, 32'd0);
        check("R11", "zero quieted", quieted, 32'd0);

        // R2: both infinities in every mode
        all_modes(32'h7F80_0000);
        all_modes(32'hFF80_0000);
        // R12: field positions for single; bit 22 is the top fraction bit
        apply(32'h7FC0_0000, 1'b0, 1'b0);
        check("R12", "bit22 quiet", {31'd0, is_qnan}, 32'd1);
        apply(32'h7F80_0001, 1'b0, 1'b0);
        check("R12", "lsb-only snan", {31'd0, is_snan}, 32'd1);
        // corner payloads
        all_modes(32'h7F80_0001);
        all_modes(32'hFFBF_FFFF);
        all_modes(32'h7FFF_FFFF);
        all_modes(32'hFFC0_1234);
        all_modes(32'h7F40_0000);
        all_modes(32'h7F00_0001);
        // R10: payload ignored under inverted polarity
        apply(32'hFFE5_A5A5, 1'b1, 1'b0);
        check("R10", "payload ignored", quieted, 32'h7FBF_FFFF);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            w = $urandom();
            if ($urandom() % 2 == 0) w[30:23] = 8'hFF;
            if ($urandom() % 4 == 0) w[21:0] = 22'd0;
            apply(w, 1'($urandom()), 1'($urandom() % 3 == 0));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule